// File: doc/BRIEF.md
# Variable Bit Field Extractor

This block takes a 64-bit window of source data and pulls out a bit field that may begin at any bit of the window. The field's start is not tied to byte boundaries. The field can be 0 to 32 bits wide. The extracted bits come back right-aligned in a 32-bit longword. Bits above the field are filled with zeros or with copies of the field's top bit, as a control input selects.

A second mode compares the extended field with a 32-bit operand. In that mode the block reports signed-less, equal and unsigned-less flags instead of a value. A request whose field would run past the top of the window, or that asks for more than 32 bits, is rejected with a reserved-operand error.

Requests are accepted with a one-cycle start strobe. The outcome is registered and appears on the next clock edge, together with a single-cycle done pulse. It then stays on the outputs until the next start.

Top module: `bfx_unit`

## Requirements
- R1: With `start` high, the block sets `result[i]` = `src_data[bit_pos+i]` for every i below `fld_size`. This holds for any `bit_pos`, including fields that cross byte boundaries and fields that end at window bit 63.
- R2: Every field width from 0 to 32 is accepted. A width of 32 returns 32 window bits, and no extension is applied.
- R3: A `fld_size` of 0 returns an all-zero `result`, whatever the value of `sign_ext`.
- R4: With `sign_ext` low and `fld_size` below 32, every `result` bit at or above `fld_size` is 0.
- R5: With `sign_ext` high and `fld_size` from 1 to 31, every `result` bit at or above `fld_size` equals window bit `bit_pos+fld_size-1`.
- R6: If `bit_pos+fld_size` is greater than 64, or `fld_size` is greater than 32, the block sets `rsvd_err` to 1 and sets `result` and all three flags to 0. This applies in both modes.
- R7: With `cmp_mode` high, the block sets `result` to 0. `flag_n` is 1 when the extended field is below `cmp_op` as signed values. `flag_z` is 1 when they are equal. `flag_c` is 1 when the field is below `cmp_op` as unsigned values.
- R8: With `cmp_mode` low, all three flags are 0 and `rsvd_err` is 0 for a legal request.
- R9: `done` is 1 in exactly the cycle after each `start` and 0 in every other cycle. Starts may come on back-to-back cycles. Without `start`, `result`, the flags and `rsvd_err` keep their values.
- R10: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle per request |
| src_data | input | 64 | Source window |
| bit_pos | input | 6 | Bit index of the field's lowest bit |
| fld_size | input | 6 | Field width in bits (legal 0 to 32) |
| sign_ext | input | 1 | 1 = sign-extend, 0 = zero-extend |
| cmp_mode | input | 1 | 1 = compare with cmp_op, 0 = return the field |
| cmp_op | input | 32 | Longword that the field is compared with |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Extended field (0 in compare mode or on error) |
| flag_n | output | 1 | Signed less-than flag |
| flag_z | output | 1 | Equal flag |
| flag_c | output | 1 | Unsigned less-than flag |
| rsvd_err | output | 1 | Reserved-operand error |

## Verification
The bench builds the block with its default sizes: a 64-bit window, a 32-bit longword and 6-bit position and width inputs. With these sizes the bench can reach every start position. It can also reach fields that end exactly at window bit 63, widths one past the legal maximum, and positions where `bit_pos+fld_size` overflows the window by a single bit. The compare cases use fields whose signed and unsigned orderings disagree, so a swapped flag gives a wrong output.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } bfx_flags_t;
endpackage

// File: rtl/bfx_range.sv
module bfx_range #(
  parameter int SRC_W  = 64,
  parameter int RES_W  = 32,
  parameter int POS_W  = $clog2(SRC_W),
  parameter int SIZE_W = $clog2(SRC_W)
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [SIZE_W-1:0] size,
  output logic              bad
);
  localparam int SUM_W = ((POS_W > SIZE_W) ? POS_W : SIZE_W) + 1;
  logic [SUM_W-1:0] span;
  assign span = SUM_W'(pos) + SUM_W'(size);
  assign bad  = (span > SUM_W'(SRC_W)) || (SUM_W'(size) > SUM_W'(RES_W));
endmodule

// File: rtl/bfx_shifter.sv
module bfx_shifter #(
  parameter int SRC_W = 64,
  parameter int RES_W = 32,
  parameter int POS_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src,
  input  logic [POS_W-1:0] pos,
  output logic [RES_W-1:0] raw
);
  logic [SRC_W-1:0] aligned;
  assign aligned = src >> pos;
  assign raw     = aligned[RES_W-1:0];
endmodule

// File: rtl/bfx_extend.sv
module bfx_extend #(
  parameter int RES_W  = 32,
  parameter int SIZE_W = 6
) (
  input  logic [RES_W-1:0]  raw,
  input  logic [SIZE_W-1:0] size,
  input  logic              sign_ext,
  output logic [RES_W-1:0]  field
);
  localparam int IDX_W = $clog2(RES_W);
  logic [SIZE_W-1:0] top_idx;
  logic              top_bit;
  logic              fill;

  assign top_idx = size - SIZE_W'(1);
  assign top_bit = (size != '0) ? raw[top_idx[IDX_W-1:0]] : 1'b0;
  assign fill    = sign_ext & top_bit;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    assign field[i] = (SIZE_W'(i) < size) ? raw[i] : fill;
  end
endmodule

// File: rtl/bfx_compare.sv
module bfx_compare
  import bfx_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic [RES_W-1:0] lhs,
  input  logic [RES_W-1:0] rhs,
  output bfx_flags_t       flags
);
  assign flags.n = $signed(lhs) < $signed(rhs);
  assign flags.z = lhs == rhs;
  assign flags.c = lhs < rhs;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int SRC_W  = 64,
  parameter int RES_W  = 32,
  parameter int POS_W  = $clog2(SRC_W),
  parameter int SIZE_W = $clog2(SRC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SRC_W-1:0]  src_data,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic [SIZE_W-1:0] fld_size,
  input  logic              sign_ext,
  input  logic              cmp_mode,
  input  logic [RES_W-1:0]  cmp_op,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              rsvd_err
);
  logic [RES_W-1:0] raw;
  logic [RES_W-1:0] field;
  logic             bad;
  bfx_flags_t       cmp_flags;

  bfx_range #(.SRC_W(SRC_W), .RES_W(RES_W), .POS_W(POS_W), .SIZE_W(SIZE_W)) u_range (
    .pos(bit_pos), .size(fld_size), .bad(bad)
  );

  bfx_shifter #(.SRC_W(SRC_W), .RES_W(RES_W), .POS_W(POS_W)) u_shift (
    .src(src_data), .pos(bit_pos), .raw(raw)
  );

  bfx_extend #(.RES_W(RES_W), .SIZE_W(SIZE_W)) u_ext (
    .raw(raw), .size(fld_size), .sign_ext(sign_ext), .field(field)
  );

  bfx_compare #(.RES_W(RES_W)) u_cmp (
    .lhs(field), .rhs(cmp_op), .flags(cmp_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      result   <= '0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_c   <= 1'b0;
      rsvd_err <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        if (bad) begin
          result   <= '0;
          flag_n   <= 1'b0;
          flag_z   <= 1'b0;
          flag_c   <= 1'b0;
          rsvd_err <= 1'b1;
        end else if (cmp_mode) begin
          result   <= '0;
          flag_n   <= cmp_flags.n;
          flag_z   <= cmp_flags.z;
          flag_c   <= cmp_flags.c;
          rsvd_err <= 1'b0;
        end else begin
          result   <= field;
          flag_n   <= 1'b0;
          flag_z   <= 1'b0;
          flag_c   <= 1'b0;
          rsvd_err <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int SRC_W  = 64,
  parameter int RES_W  = 32,
  parameter int POS_W  = $clog2(SRC_W),
  parameter int SIZE_W = $clog2(SRC_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [SRC_W-1:0]  src_data,
  input logic [POS_W-1:0]  bit_pos,
  input logic [SIZE_W-1:0] fld_size,
  input logic              sign_ext,
  input logic              cmp_mode,
  input logic [RES_W-1:0]  cmp_op,
  input logic              done,
  input logic [RES_W-1:0]  result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              rsvd_err
);
  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst) start |=> done); // R9
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) !start |=> !done); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result) && $stable(rsvd_err)); // R9
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst) rsvd_err |-> result == '0 && !flag_n && !flag_z && !flag_c); // R6
  AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (rst) start && fld_size == '0 && !cmp_mode |=> result == '0); // R3
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    start && !sign_ext && !cmp_mode && fld_size < SIZE_W'(RES_W) |=> (result >> $past(fld_size)) == '0); // R4
  AST_EXTRACT_FLAGS: assert property (@(posedge clk) disable iff (rst) start && !cmp_mode |=> !flag_n && !flag_z && !flag_c); // R8
  AST_EQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) flag_z |-> !flag_n && !flag_c); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !done); // R10
endmodule

bind bfx_unit bfx_unit_chk #(.SRC_W(SRC_W), .RES_W(RES_W), .POS_W(POS_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/bfx_unit_bench.sv
`timescale 1ns/1ps
module bfx_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] src_data = '0;
  logic [5:0]  bit_pos = '0;
  logic [5:0]  fld_size = '0;
  logic        sign_ext = 1'b0;
  logic        cmp_mode = 1'b0;
  logic [31:0] cmp_op = '0;
  logic        done;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, rsvd_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic        e_done = 1'b0;
  logic [31:0] e_res = '0;
  logic        e_n = 1'b0, e_z = 1'b0, e_c = 1'b0, e_err = 1'b0;
  string       e_tag = "R10";

  always #2.5 clk = ~clk;

  bfx_unit u_bfx_unit (
    .clk(clk), .rst(rst), .start(start), .src_data(src_data), .bit_pos(bit_pos),
    .fld_size(fld_size), .sign_ext(sign_ext), .cmp_mode(cmp_mode), .cmp_op(cmp_op),
    .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .rsvd_err(rsvd_err)
  );

  task automatic check_now();
    checks++;
    if (done !== e_done || result !== e_res || flag_n !== e_n || flag_z !== e_z ||
        flag_c !== e_c || rsvd_err !== e_err) begin
      errors++;
      $display("FAIL %s: got done=%0b res=%h nzc=%b%b%b err=%b, expected done=%0b res=%h nzc=%b%b%b err=%b",
               e_tag, done, result, flag_n, flag_z, flag_c, rsvd_err,
               e_done, e_res, e_n, e_z, e_c, e_err);
    end
  endtask

  // one cycle: check outputs, drive inputs, predict the next cycle
  task automatic step(input bit st, input logic [63:0] src, input int pos, input int sz,
                      input bit sx, input bit cm, input logic [31:0] op, input string tag);
    logic [31:0] f;
    @(negedge clk);
    check_now();
    start = st; src_data = src; bit_pos = 6'(pos); fld_size = 6'(sz);
    sign_ext = sx; cmp_mode = cm; cmp_op = op;
    e_done = st;
    if (st) begin
      e_tag = tag;
      e_n = 0; e_z = 0; e_c = 0; e_err = 0; e_res = '0;
      if (pos + sz > 64 || sz > 32) begin
        e_err = 1;
      end else begin
        f = '0;
        for (int i = 0; i < sz; i++) f[i] = src[pos + i];
        if (sx && sz > 0) for (int i = sz; i < 32; i++) f[i] = src[pos + sz - 1];
        if (cm) begin
          e_n = $signed(f) < $signed(op);
          e_z = f == op;
          e_c = f < op;
        end else begin
          e_res = f;
        end
      end
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, src_data, 0, 0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now();                 // R10 reset state while rst is high
    rst = 1'b0;
    idle("R10");
    // R1 / R8 extraction at several positions
    step(1, 64'h0123_4567_89AB_CDEF, 0, 8, 0, 0, 0, "R1");
    step(1, 64'h0123_4567_89AB_CDEF, 13, 11, 0, 0, 0, "R1");
    step(1, 64'hF000_0000_0000_0000, 60, 4, 0, 0, 0, "R1");
    step(1, 64'hA5A5_5A5A_0F0F_F0F0, 37, 19, 0, 0, 0, "R8");
    // R2 full-width fields
    step(1, 64'hDEAD_BEEF_CAFE_F00D, 32, 32, 1, 0, 0, "R2");
    step(1, 64'hDEAD_BEEF_CAFE_F00D, 0, 32, 0, 0, 0, "R2");
    // R3 zero width
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 63, 0, 1, 0, 0, "R3");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 5, 0, 0, 0, 0, "R3");
    // R4 / R5 extension
    step(1, 64'h0000_0000_0000_0F80, 7, 5, 0, 0, 0, "R4");
    step(1, 64'h0000_0000_0000_0F80, 7, 5, 1, 0, 0, "R5");
    step(1, 64'h0000_0000_0000_0780, 7, 5, 1, 0, 0, "R5");
    step(1, 64'h8000_0000_0000_0000, 63, 1, 1, 0, 0, "R5");
    // R6 reserved operand
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 40, 25, 0, 0, 0, "R6");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 33, 1, 0, 0, "R6");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 33, 32, 0, 1, 32'h1, "R6");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 32, 32, 0, 0, 0, "R2");
    // R7 compare
    step(1, 64'h0000_0000_0000_00F0, 4, 4, 1, 1, 32'h0000_0001, "R7");
    step(1, 64'h0000_0000_0000_00F0, 4, 4, 0, 1, 32'h0000_0001, "R7");
    step(1, 64'h0000_0000_0000_00F0, 4, 4, 0, 1, 32'h0000_000F, "R7");
    step(1, 64'h0000_0000_0000_00F0, 4, 4, 1, 1, 32'hFFFF_FFFF, "R7");
    step(1, 64'h0000_0000_0000_0030, 4, 4, 0, 1, 32'h8000_0000, "R7");
    // R9 holding and back-to-back
    idle("R9");
    idle("R9");
    step(1, 64'h1357_9BDF_2468_ACE0, 9, 17, 1, 0, 0, "R9");
    step(1, 64'h1357_9BDF_2468_ACE0, 21, 30, 0, 0, 0, "R9");
    idle("R9");
    // pseudo-random sweep
    for (int k = 0; k < 300; k++) begin
      step(1'($urandom_range(0, 3) != 0), {$urandom, $urandom}, int'($urandom_range(0, 63)),
           int'($urandom_range(0, 34)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           $urandom, "R1");
    end
    idle("R9");
    idle("R9");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule